// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits between the source clocks of a clock generator and its output pins. It decides, output by output, when each clock may toggle. Three active-low control pins drive it: a processor-clock halt, a bus-clock halt and a power-down request. All of its sequencing runs on a free-running bus-rate reference clock. Every stop and restart is counted in rising edges of that reference. The actual gating happens in a small cell per output that only changes state while its source clock is low, so an output always parks low and never emits a shortened pulse.

Power-down silences every output, withdraws the oscillator/VCO enable once the gated clocks have been released, and on exit runs a timed wake interval before any clock returns. The wake interval is a parameterised count of reference cycles. The reference-rate clock and the two interrupt-controller clocks also obey a small enable register. It powers up with every bit set, and a cleared bit holds the matching output low. Two status outputs report whether every gate is closed and whether the three sequenced clocks (processor, bus, memory) are all open.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While reset is high, all six gated outputs are low, `osc_en` is 0, `all_stopped` is 1 and `all_valid` is 0.
- R2: With `cpu_stop_n` = 0 and power-down inactive, `cpu_clk` stays low while `pci_clk` and `sdram_clk` keep toggling.
- R3: With `pci_stop_n` = 0 and power-down inactive, `pci_clk` stays low while `cpu_clk` and `sdram_clk` keep toggling.
- R4: A halt pin driven low is seen after a two-stage synchronizer. The gate request then drops on the next `clk_free` rising edge, so after the 2nd rising edge the output is still open and after the 3rd it is closed.
- R5: A halt pin driven high reopens its clock after two counted edges beyond the synchronizer. The clock is still closed after the 3rd rising edge and open after the 4th.
- R6: While `pwr_dn_n` is 0, all six gated outputs stay low and `all_stopped` is 1, for every combination of the two halt pins.
- R7: `osc_en` is still 1 after the 3rd rising edge after `pwr_dn_n` falls and is 0 after the 4th. After `pwr_dn_n` rises, `osc_en` is 0 after the 2nd edge and 1 after the 3rd.
- R8: After reset release or power-down exit, the sequenced clocks open only after a wake interval of WAKE_CYCLES reference cycles. `all_valid` is 0 after rising edge WAKE_CYCLES+3 and 1 after edge WAKE_CYCLES+4.
- R9: The enable register is written with `reg_we` at a `clk_free` rising edge and resets to all ones. Bit 0 enables `ref_clk`, bit 4 enables `apic0_clk` and bit 5 enables `apic1_clk`. A 0 holds that output low. The other bits have no effect.
- R10: Every high pulse of a gated output lasts exactly one high phase of its source clock, and gate changes happen only while the source is low.
- R11: `all_stopped` is 1 exactly when all six gates are closed. `all_valid` is 1 exactly when the processor, bus and memory gates are all open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_free | input | 1 | Free-running bus-rate reference; clocks all sequencing |
| rst | input | 1 | Synchronous active-high reset |
| cpu_stop_n | input | 1 | Asynchronous processor-clock halt, active low |
| pci_stop_n | input | 1 | Asynchronous bus-clock halt, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down request, active low |
| src_cpu | input | 1 | Processor source clock |
| src_pci | input | 1 | Bus source clock |
| src_sdram | input | 1 | Memory source clock |
| src_ref | input | 1 | Reference-rate source clock |
| src_apic | input | 1 | Interrupt-controller source clock (feeds both outputs) |
| reg_we | input | 1 | Enable-register write strobe |
| reg_wdata | input | 8 | Enable-register write data |
| cpu_clk | output | 1 | Gated processor clock |
| pci_clk | output | 1 | Gated bus clock |
| sdram_clk | output | 1 | Gated memory clock |
| ref_clk | output | 1 | Gated reference clock |
| apic0_clk | output | 1 | Gated interrupt-controller clock 0 |
| apic1_clk | output | 1 | Gated interrupt-controller clock 1 |
| osc_en | output | 1 | Oscillator/VCO enable |
| all_stopped | output | 1 | All six gates closed |
| all_valid | output | 1 | Processor, bus and memory gates all open |

## Verification
A restart counter stuck or off by one moves the edge at which `all_valid` rises for a halt release or a wake interval. That error shows within one reference cycle of the expected edge, and the bench samples on both sides of that edge. A gate cell clocked on the wrong source edge lets a clock change mid-pulse. The pulse-width monitors catch the first short high phase. A bad synchronizer depth or a power-down path that skips a channel appears within a few cycles as an output that toggles, or stays low, when the pin pattern says otherwise.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    localparam int NCH   = 6;
    localparam int NSEQ  = 3;

    localparam int CH_CPU   = 0;
    localparam int CH_PCI   = 1;
    localparam int CH_SDRAM = 2;
    localparam int CH_REF   = 3;
    localparam int CH_APIC0 = 4;
    localparam int CH_APIC1 = 5;

    localparam int EN_REF_BIT   = 0;
    localparam int EN_APIC0_BIT = 4;
    localparam int EN_APIC1_BIT = 5;

    typedef struct packed {
        logic pd_up;
        logic pci_run;
        logic cpu_run;
    } ctrl_sync_t;

    typedef struct packed {
        logic apic1;
        logic apic0;
        logic refc;
    } periph_en_t;

    function automatic int start_edges(input int ch);
        return (ch < NSEQ) ? 2 : 1;
    endfunction

endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/clk_stop_chan.sv
module clk_stop_chan #(
    parameter int START_EDGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic want,
    output logic req
);
    localparam int CW = $clog2(START_EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(START_EDGES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !want) begin
            req <= 1'b0;
            cnt <= '0;
        end else if (!req) begin
            if (cnt == LAST) req <= 1'b1;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate (
    input  logic src,
    input  logic rst,
    input  logic req,
    output logic gate,
    output logic gclk
);
    always_ff @(negedge src) begin
        if (rst) gate <= 1'b0;
        else     gate <= req;
    end

    assign gclk = src & gate;
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import clk_stop_pkg::*;
#(
    parameter int WAKE_CYCLES = 100000
) (
    input  logic       clk_free,
    input  logic       rst,
    input  logic       cpu_stop_n,
    input  logic       pci_stop_n,
    input  logic       pwr_dn_n,
    input  logic       src_cpu,
    input  logic       src_pci,
    input  logic       src_sdram,
    input  logic       src_ref,
    input  logic       src_apic,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic       cpu_clk,
    output logic       pci_clk,
    output logic       sdram_clk,
    output logic       ref_clk,
    output logic       apic0_clk,
    output logic       apic1_clk,
    output logic       osc_en,
    output logic       all_stopped,
    output logic       all_valid
);
    localparam int WW = $clog2(WAKE_CYCLES + 1);
    localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYCLES - 1);

    ctrl_sync_t sy;
    logic       pd_up_s, cpu_run_s;

    clk_stop_sync #(.W(3)) u_sync (
        .clk (clk_free),
        .rst (rst),
        .d   ({pwr_dn_n, pci_stop_n, cpu_stop_n}),
        .q   (sy)
    );
    assign pd_up_s   = sy.pd_up;
    assign cpu_run_s = sy.cpu_run;

    // Peripheral enables, all set at reset
    periph_en_t pen;
    logic       unused_wdata;
    assign unused_wdata = ^{reg_wdata[7:6], reg_wdata[3:1]};

    always_ff @(posedge clk_free) begin
        if (rst)         pen <= '1;
        else if (reg_we) pen <= '{apic1: reg_wdata[EN_APIC1_BIT],
                                  apic0: reg_wdata[EN_APIC0_BIT],
                                  refc:  reg_wdata[EN_REF_BIT]};
    end

    // Wake interval after power-down exit or reset
    logic [WW-1:0] wake_cnt;
    logic          wake_done;

    always_ff @(posedge clk_free) begin
        if (rst || !pd_up_s) begin
            wake_cnt  <= '0;
            wake_done <= 1'b0;
        end else if (!wake_done) begin
            if (wake_cnt == WAKE_LAST) wake_done <= 1'b1;
            else                       wake_cnt  <= wake_cnt + 1'b1;
        end
    end

    logic awake;
    assign awake = pd_up_s & wake_done;

    logic [NCH-1:0] want, req, gate, gclk, src_vec;

    always_comb begin
        want            = '0;
        want[CH_CPU]    = awake & sy.cpu_run;
        want[CH_PCI]    = awake & sy.pci_run;
        want[CH_SDRAM]  = awake;
        want[CH_REF]    = awake & pen.refc;
        want[CH_APIC0]  = awake & pen.apic0;
        want[CH_APIC1]  = awake & pen.apic1;
    end

    assign src_vec = {src_apic, src_apic, src_ref, src_sdram, src_pci, src_cpu};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        clk_stop_chan #(.START_EDGES(start_edges(i))) u_chan (
            .clk  (clk_free),
            .rst  (rst),
            .want (want[i]),
            .req  (req[i])
        );
        clk_stop_gate u_gate (
            .src  (src_vec[i]),
            .rst  (rst),
            .req  (req[i]),
            .gate (gate[i]),
            .gclk (gclk[i])
        );
    end

    // Oscillator stays on until every gate request has been withdrawn
    logic osc_q;
    always_ff @(posedge clk_free) begin
        if (rst) osc_q <= 1'b0;
        else     osc_q <= pd_up_s | (|req);
    end

    assign osc_en      = osc_q;
    assign cpu_clk     = gclk[CH_CPU];
    assign pci_clk     = gclk[CH_PCI];
    assign sdram_clk   = gclk[CH_SDRAM];
    assign ref_clk     = gclk[CH_REF];
    assign apic0_clk   = gclk[CH_APIC0];
    assign apic1_clk   = gclk[CH_APIC1];
    assign all_stopped = ~|gate;
    assign all_valid   = &gate[NSEQ-1:0];
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk
    import clk_stop_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           osc_en,
    input logic           pd_sync,
    input logic           cpu_sync,
    input logic [NCH-1:0] want,
    input logic [NCH-1:0] req
);
    p_rst_quiet_r1: assert property (@(posedge clk)
        rst |=> (!osc_en && req == '0));

    p_cpu_halt_r4: assert property (@(posedge clk) disable iff (rst)
        !cpu_sync |=> !req[CH_CPU]);

    p_cpu_restart_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(req[CH_CPU]) |-> ($past(want[CH_CPU]) && $past(want[CH_CPU], 2)));

    p_pd_release_r6: assert property (@(posedge clk) disable iff (rst)
        !pd_sync |=> (req == '0));

    p_osc_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_en) |-> (req == '0));

    p_osc_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en) |-> $past(pd_sync));
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk u_chk (
    .clk      (clk_free),
    .rst      (rst),
    .osc_en   (osc_en),
    .pd_sync  (pd_up_s),
    .cpu_sync (cpu_run_s),
    .want     (want),
    .req      (req)
);

// File: tb/clk_stop_ctrl_tb.sv
module clk_stop_mon #(
    parameter int HALF = 5
) (
    input  logic gclk,
    input  logic rst,
    output int   edges,
    output int   runts
);
    int  n_edge = 0;
    int  n_runt = 0;
    time t_rise = 0;
    bit  armed  = 0;

    always @(posedge gclk) if (!rst) begin
        n_edge <= n_edge + 1;
        t_rise <= $time;
        armed  <= 1'b1;
    end

    always @(negedge gclk) if (armed && !rst) begin
        if ($time - t_rise != HALF) n_runt <= n_runt + 1;
    end

    assign edges = n_edge;
    assign runts = n_runt;
endmodule

module clk_stop_ctrl_tb;
    localparam int WAKE = 20;

    logic clk = 0, rst = 1;
    logic cpu_stop_n = 1, pci_stop_n = 1, pwr_dn_n = 1, reg_we = 0;
    logic [7:0] reg_wdata = 8'h00;
    logic src_cpu = 0, src_sdram = 0, src_ref = 0, src_apic = 0;
    logic cpu_clk, pci_clk, sdram_clk, ref_clk, apic0_clk, apic1_clk;
    logic osc_en, all_stopped, all_valid;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;
    initial begin #2; forever #5  src_cpu   = ~src_cpu;   end
    initial begin #3; forever #5  src_sdram = ~src_sdram; end
    initial begin #1; forever #20 src_ref   = ~src_ref;   end
    initial begin #4; forever #30 src_apic  = ~src_apic;  end

    clk_stop_ctrl #(.WAKE_CYCLES(WAKE)) u_dut (
        .clk_free(clk), .rst(rst),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
        .src_cpu(src_cpu), .src_pci(clk), .src_sdram(src_sdram),
        .src_ref(src_ref), .src_apic(src_apic),
        .reg_we(reg_we), .reg_wdata(reg_wdata),
        .cpu_clk(cpu_clk), .pci_clk(pci_clk), .sdram_clk(sdram_clk),
        .ref_clk(ref_clk), .apic0_clk(apic0_clk), .apic1_clk(apic1_clk),
        .osc_en(osc_en), .all_stopped(all_stopped), .all_valid(all_valid)
    );

    function automatic int half_of(input int i);
        case (i)
            0, 2:    return 5;
            1:       return 10;
            3:       return 20;
            default: return 30;
        endcase
    endfunction

    logic [5:0] gv;
    assign gv = {apic1_clk, apic0_clk, ref_clk, sdram_clk, pci_clk, cpu_clk};

    int edges [6];
    int runts [6];
    int delta [6];

    for (genvar i = 0; i < 6; i++) begin : g_mon
        clk_stop_mon #(.HALF(half_of(i))) u_mon (
            .gclk(gv[i]), .rst(rst), .edges(edges[i]), .runts(runts[i]));
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #15;
    endtask

    task automatic window();
        int s [6];
        for (int i = 0; i < 6; i++) s[i] = edges[i];
        repeat (4) @(posedge clk);
        #15;
        for (int i = 0; i < 6; i++) delta[i] = edges[i] - s[i];
    endtask

    task automatic write_en(input logic [7:0] w);
        @(negedge clk);
        reg_we    <= 1'b1;
        reg_wdata <= w;
        @(negedge clk);
        reg_we    <= 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(5);
        chk("R1 outputs low", int'(gv), 0);
        chk("R1 osc_en", int'(osc_en), 0);
        chk("R1 all_stopped", int'(all_stopped), 1);
        chk("R1 all_valid", int'(all_valid), 0);

        // R8 wake interval after reset release
        @(negedge clk) rst <= 1'b0;
        step(3 + WAKE);
        chk("R8 not yet valid after reset", int'(all_valid), 0);
        step(1);
        chk("R8 valid after reset", int'(all_valid), 1);

        // R9 reset default enables
        window();
        chk("R9 ref default on", int'(delta[3] > 0), 1);
        chk("R9 apic0 default on", int'(delta[4] > 0), 1);
        chk("R9 apic1 default on", int'(delta[5] > 0), 1);

        // R2 R3 R11 sweep of halt pins
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            cpu_stop_n <= c[0];
            pci_stop_n <= c[1];
            repeat (8) @(posedge clk);
            window();
            chk("R2 cpu_clk running", int'(delta[0] > 0), c[0]);
            chk("R3 pci_clk running", int'(delta[1] > 0), c[1]);
            chk("R2 sdram_clk running", int'(delta[2] > 0), 1);
            chk("R11 all_valid", int'(all_valid), int'(c == 3));
            chk("R11 all_stopped", int'(all_stopped), 0);
        end

        // R4 R5 latency, processor halt
        @(negedge clk) cpu_stop_n <= 1'b0;
        step(2);
        chk("R4 cpu open after edge 2", int'(all_valid), 1);
        step(1);
        chk("R4 cpu closed after edge 3", int'(all_valid), 0);
        chk("R4 cpu_clk low", int'(cpu_clk), 0);
        @(negedge clk) cpu_stop_n <= 1'b1;
        step(3);
        chk("R5 cpu closed after edge 3", int'(all_valid), 0);
        step(1);
        chk("R5 cpu open after edge 4", int'(all_valid), 1);

        // R4 R5 latency, bus halt
        @(negedge clk) pci_stop_n <= 1'b0;
        step(2);
        chk("R4 pci open after edge 2", int'(all_valid), 1);
        step(1);
        chk("R4 pci closed after edge 3", int'(all_valid), 0);
        @(negedge clk) pci_stop_n <= 1'b1;
        step(3);
        chk("R5 pci closed after edge 3", int'(all_valid), 0);
        step(1);
        chk("R5 pci open after edge 4", int'(all_valid), 1);

        // R7 power-down entry
        @(negedge clk) pwr_dn_n <= 1'b0;
        step(3);
        chk("R7 osc_en held after edge 3", int'(osc_en), 1);
        step(1);
        chk("R7 osc_en off after edge 4", int'(osc_en), 0);
        repeat (4) @(posedge clk);

        // R6 sweep of halt pins during power-down
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            cpu_stop_n <= c[0];
            pci_stop_n <= c[1];
            repeat (6) @(posedge clk);
            window();
            chk("R6 no edges in power-down",
                delta[0] + delta[1] + delta[2] + delta[3] + delta[4] + delta[5], 0);
            chk("R6 outputs low", int'(gv), 0);
            chk("R6 all_stopped", int'(all_stopped), 1);
        end

        // R7 R8 power-down exit
        @(negedge clk);
        cpu_stop_n <= 1'b1;
        pci_stop_n <= 1'b1;
        @(negedge clk) pwr_dn_n <= 1'b1;
        step(2);
        chk("R7 osc_en off after edge 2", int'(osc_en), 0);
        step(1);
        chk("R7 osc_en on after edge 3", int'(osc_en), 1);
        step(WAKE);
        chk("R8 not valid at wake+3", int'(all_valid), 0);
        step(1);
        chk("R8 valid at wake+4", int'(all_valid), 1);

        // R9 exhaustive sweep of the three enable bits, reserved bits varied
        for (int v = 0; v < 8; v++) begin
            logic [7:0] w;
            w = {v[1], v[0], v[2], v[1], v[2], v[1], v[0], v[0]};
            write_en(w);
            repeat (8) @(posedge clk);
            window();
            chk("R9 ref_clk follows bit 0", int'(delta[3] > 0), v[0]);
            chk("R9 apic0_clk follows bit 4", int'(delta[4] > 0), v[1]);
            chk("R9 apic1_clk follows bit 5", int'(delta[5] > 0), v[2]);
            chk("R9 sequenced clocks unaffected", int'(all_valid), 1);
        end
        write_en(8'hFF);
        repeat (8) @(posedge clk);

        // R10 no shortened pulses on any output
        for (int i = 0; i < 6; i++) chk("R10 short pulses", runts[i], 0);

        done = 1;
        summary();
        $finish;
    end
endmodule